// File: doc/BRIEF.md
# Multiport Packet FIFO Host Interface

This block is the host-side front end of an eight-port packet engine. Each port owns a transmit FIFO and a receive FIFO, both clocked by the single system clock. The host writes transmit words and reads receive words over one of three bus arrangements, chosen by a static mode input. In the wide mode one 64-bit lane pair carries either direction. In the narrow mode only the low 32 bits and the low four byte enables are used. In the split mode transmit traffic rides the upper 32-bit lane and receive traffic the lower one, so a write and a read can happen in the same cycle. The line-side engine (outside this block) fills the receive FIFOs and drains the transmit FIFOs through a simple push/pop port.

Every word carries active-low byte enables, one per byte, with bit k covering data bits [8k+7:8k]. A transmit word is accepted only if its enabled bytes form one contiguous run of at least one byte. A receive word also carries start-of-packet, end-of-packet and receive-fail markers. A keep input lets the host look at the head word without taking it off the FIFO. There is no ready signal at either edge. A select that is asserted is a transfer request for that cycle. A request that cannot complete (full, empty or malformed) has no effect on the FIFOs and leaves a sticky flag, so the host must pace itself with the flags and its own counts.

Top module: `pkt_host_if`

## Requirements
- R1: While rst_n is low, every FIFO is emptied and tx_be_err, ovf_flag and unf_flag return to 0, so that mac_tx_avail and mac_rx_full read 0 after reset.
- R2: In the wide mode, a cycle with tx_sel_n low and rx_sel_n high writes {wr_be_n, wr_data} into the transmit FIFO of port port_sel at the clock edge. The line side then sees the words of that port in write order on mac_tx_data/mac_tx_be_n, and mac_tx_avail[p] is 1 while port p holds a word.
- R3: While rx_sel_n is low and the selected receive FIFO is not empty, rd_drive is 1 and rd_data, rd_be_n, rd_sop, rd_eop and rd_fail show its head word in that same cycle. The word is removed at the clock edge unless keep is asserted.
- R4: A transmit write whose asserted (low) byte enables, after lane selection, are not one contiguous run or are all deasserted is dropped and sets tx_be_err, which stays 1 until reset. For example, 8'hAF and 8'hFF are rejected in the wide mode and 8'h81 is accepted.
- R5: While rx_sel_n is high, rd_drive is 0, rd_data and rd_be_n are all ones (idle level), and rd_sop, rd_eop and rd_fail are 0.
- R6: In the narrow mode, transmit uses wr_data[31:0] and wr_be_n[3:0] only. The upper lines are ignored and the word is stored with its upper data at 0 and upper enables at 1. Reads show the low 32 bits and low 4 enables of the head word, and rd_data[63:32] and rd_be_n[7:4] are held at all ones.
- R7: In the split mode, transmit takes wr_data[63:32] and wr_be_n[7:4] into the low lane of port tx_port. Receive uses port_sel and presents on rd_data[31:0] and rd_be_n[3:0] with the upper read lines at ones. A write and a read in the same cycle both complete.
- R8: A read with rx_keep high leaves the head word in place, so the next read of that port shows the same word. rx_keep has no effect while rx_sel_n is high.
- R9: A well-formed write to a full transmit FIFO (DEPTH words) is not stored and sets ovf_flag[port] until reset.
- R10: A read of an empty receive FIFO drives rd_drive 1, rd_data 0, rd_be_n all ones and markers 0, and it sets unf_flag[port_sel] until reset.
- R11: In the wide and narrow modes, when tx_sel_n and rx_sel_n are both low the read is served and the write is ignored.
- R12: bus_mode encodes 0 wide, 1 narrow, 2 split, and 3 acts as wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, flushes all FIFOs |
| bus_mode | input | 2 | Bus arrangement (0 wide, 1 narrow, 2 split, 3 wide) |
| port_sel | input | 3 | Port for wide/narrow transfers and split-mode reads |
| tx_port | input | 3 | Port for split-mode writes |
| tx_sel_n | input | 1 | Active-low transmit write request |
| rx_sel_n | input | 1 | Active-low receive read request |
| rx_keep | input | 1 | Keep the head word on this read |
| wr_data | input | 64 | Host write data lanes |
| wr_be_n | input | 8 | Host write byte enables, active low |
| rd_data | output | 64 | Host read data lanes |
| rd_be_n | output | 8 | Host read byte enables, active low |
| rd_sop | output | 1 | Start-of-packet of the word read |
| rd_eop | output | 1 | End-of-packet of the word read |
| rd_fail | output | 1 | Receive-fail marker of the word read |
| rd_drive | output | 1 | Read lines are driven (else idle level) |
| tx_be_err | output | 1 | Sticky malformed byte-enable flag |
| ovf_flag | output | 8 | Sticky per-port transmit overflow |
| unf_flag | output | 8 | Sticky per-port receive underflow |
| mac_rx_push | input | 1 | Line side pushes a receive word |
| mac_rx_port | input | 3 | Port of the receive push |
| mac_rx_data | input | 64 | Receive word data |
| mac_rx_be_n | input | 8 | Receive word byte enables |
| mac_rx_sop | input | 1 | Receive word start-of-packet |
| mac_rx_eop | input | 1 | Receive word end-of-packet |
| mac_rx_fail | input | 1 | Receive word fail marker |
| mac_rx_full | output | 8 | Per-port receive FIFO full |
| mac_tx_pop | input | 1 | Line side takes a transmit word |
| mac_tx_port | input | 3 | Port the line side reads |
| mac_tx_avail | output | 8 | Per-port transmit FIFO non-empty |
| mac_tx_data | output | 64 | Head transmit word data of mac_tx_port |
| mac_tx_be_n | output | 8 | Head transmit word byte enables |

## Verification
The bench builds the block with its defaults: eight ports, a 16-word depth and 64-bit lanes. The shallow depth puts the overflow boundary within seventeen writes, and the bench checks that the seventeenth write leaves exactly sixteen words behind. Eight ports allow the tests to use port 7, the top of the 3-bit select, and to run split-mode writes and reads on different ports at once. With 64-bit lanes, the lane steering of all three modes can be seen on the same pins.

// File: rtl/pkthost_pkg.sv
package pkthost_pkg;

  typedef enum logic [1:0] {
    MODE_WIDE     = 2'd0,
    MODE_NARROW   = 2'd1,
    MODE_SPLIT    = 2'd2,
    MODE_WIDE_ALT = 2'd3
  } bus_mode_e;

  function automatic logic lanes_halved(input bus_mode_e m);
    return (m == MODE_NARROW) || (m == MODE_SPLIT);
  endfunction

endpackage

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
  parameter int W     = 72,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tx_lane_norm.sv
module tx_lane_norm
  import pkthost_pkg::*;
#(
  parameter int DW = 64
) (
  input  bus_mode_e         mode,
  input  logic [DW-1:0]     wr_data,
  input  logic [DW/8-1:0]   wr_be_n,
  output logic [DW-1:0]     norm_data,
  output logic [DW/8-1:0]   norm_be_n,
  output logic              be_ok
);
  localparam int NB = DW / 8;
  localparam int HB = NB / 2;
  localparam int HW = DW / 2;

  logic [NB-1:0] en;
  logic          prev;
  int            runs;

  always_comb begin
    case (mode)
      MODE_NARROW: begin
        norm_data = {{HW{1'b0}}, wr_data[HW-1:0]};
        norm_be_n = {{HB{1'b1}}, wr_be_n[HB-1:0]};
      end
      MODE_SPLIT: begin
        norm_data = {{HW{1'b0}}, wr_data[DW-1:HW]};
        norm_be_n = {{HB{1'b1}}, wr_be_n[NB-1:HB]};
      end
      default: begin
        norm_data = wr_data;
        norm_be_n = wr_be_n;
      end
    endcase
  end

  // one run of enabled bytes, and at least one byte
  always_comb begin
    en   = ~norm_be_n;
    prev = 1'b0;
    runs = 0;
    for (int i = 0; i < NB; i++) begin
      if (en[i] && !prev) runs = runs + 1;
      prev = en[i];
    end
    be_ok = (runs == 1);
  end
endmodule

// File: rtl/rx_lane_present.sv
module rx_lane_present
  import pkthost_pkg::*;
#(
  parameter int DW = 64
) (
  input  bus_mode_e         mode,
  input  logic              active,
  input  logic              has_word,
  input  logic [DW-1:0]     head_data,
  input  logic [DW/8-1:0]   head_be_n,
  input  logic              head_sop,
  input  logic              head_eop,
  input  logic              head_fail,
  output logic [DW-1:0]     rd_data,
  output logic [DW/8-1:0]   rd_be_n,
  output logic              rd_sop,
  output logic              rd_eop,
  output logic              rd_fail,
  output logic              rd_drive
);
  localparam int NB = DW / 8;
  localparam int HB = NB / 2;
  localparam int HW = DW / 2;

  always_comb begin
    rd_drive = active;
    rd_data  = '1;
    rd_be_n  = '1;
    rd_sop   = 1'b0;
    rd_eop   = 1'b0;
    rd_fail  = 1'b0;
    if (active) begin
      if (has_word) begin
        rd_data = head_data;
        rd_be_n = head_be_n;
        rd_sop  = head_sop;
        rd_eop  = head_eop;
        rd_fail = head_fail;
      end else begin
        rd_data = '0;
      end
      if (lanes_halved(mode)) begin
        rd_data[DW-1:HW] = '1;
        rd_be_n[NB-1:HB] = '1;
      end
    end
  end
endmodule

// File: rtl/pkt_host_if.sv
module pkt_host_if
  import pkthost_pkg::*;
#(
  parameter int NPORT = 8,
  parameter int DEPTH = 16,
  parameter int DW    = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               bus_mode,
  input  logic [$clog2(NPORT)-1:0] port_sel,
  input  logic [$clog2(NPORT)-1:0] tx_port,
  input  logic                     tx_sel_n,
  input  logic                     rx_sel_n,
  input  logic                     rx_keep,
  input  logic [DW-1:0]            wr_data,
  input  logic [DW/8-1:0]          wr_be_n,
  output logic [DW-1:0]            rd_data,
  output logic [DW/8-1:0]          rd_be_n,
  output logic                     rd_sop,
  output logic                     rd_eop,
  output logic                     rd_fail,
  output logic                     rd_drive,
  output logic                     tx_be_err,
  output logic [NPORT-1:0]         ovf_flag,
  output logic [NPORT-1:0]         unf_flag,
  input  logic                     mac_rx_push,
  input  logic [$clog2(NPORT)-1:0] mac_rx_port,
  input  logic [DW-1:0]            mac_rx_data,
  input  logic [DW/8-1:0]          mac_rx_be_n,
  input  logic                     mac_rx_sop,
  input  logic                     mac_rx_eop,
  input  logic                     mac_rx_fail,
  output logic [NPORT-1:0]         mac_rx_full,
  input  logic                     mac_tx_pop,
  input  logic [$clog2(NPORT)-1:0] mac_tx_port,
  output logic [NPORT-1:0]         mac_tx_avail,
  output logic [DW-1:0]            mac_tx_data,
  output logic [DW/8-1:0]          mac_tx_be_n
);
  localparam int NB  = DW / 8;
  localparam int PW  = $clog2(NPORT);
  localparam int TXW = DW + NB;
  localparam int RXW = DW + NB + 3;

  bus_mode_e     mode;
  logic          shared_bus, wr_req, rd_req, be_ok;
  logic [PW-1:0] wport;
  logic [DW-1:0] norm_data;
  logic [NB-1:0] norm_be_n;

  logic [NPORT-1:0] tx_push, tx_pop, tx_full, tx_empty;
  logic [NPORT-1:0] rx_push, rx_pop, rx_full, rx_empty;
  logic [NPORT-1:0] ovf_set, unf_set;
  logic [TXW-1:0]   tx_head [NPORT];
  logic [RXW-1:0]   rx_head [NPORT];
  logic [RXW-1:0]   rx_sel_word;
  logic [TXW-1:0]   tx_sel_word;

  assign mode       = bus_mode_e'(bus_mode);
  assign shared_bus = (mode != MODE_SPLIT);
  assign rd_req     = !rx_sel_n;
  assign wr_req     = !tx_sel_n && !(shared_bus && rd_req);
  assign wport      = shared_bus ? port_sel : tx_port;

  tx_lane_norm #(.DW(DW)) u_txn (
    .mode      (mode),
    .wr_data   (wr_data),
    .wr_be_n   (wr_be_n),
    .norm_data (norm_data),
    .norm_be_n (norm_be_n),
    .be_ok     (be_ok)
  );

  for (genvar gp = 0; gp < NPORT; gp++) begin : g_port
    logic tx_hit, rx_hit;
    assign tx_hit      = wr_req && be_ok && (wport == PW'(gp));
    assign rx_hit      = rd_req && (port_sel == PW'(gp));
    assign tx_push[gp] = tx_hit && !tx_full[gp];
    assign ovf_set[gp] = tx_hit && tx_full[gp];
    assign tx_pop[gp]  = mac_tx_pop && (mac_tx_port == PW'(gp));
    assign rx_push[gp] = mac_rx_push && (mac_rx_port == PW'(gp));
    assign rx_pop[gp]  = rx_hit && !rx_keep;
    assign unf_set[gp] = rx_hit && rx_empty[gp];

    pkt_fifo #(.W(TXW), .DEPTH(DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_push[gp]),
      .wdata ({norm_be_n, norm_data}),
      .pop   (tx_pop[gp]),
      .rdata (tx_head[gp]),
      .full  (tx_full[gp]),
      .empty (tx_empty[gp])
    );

    pkt_fifo #(.W(RXW), .DEPTH(DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_push[gp]),
      .wdata ({mac_rx_fail, mac_rx_eop, mac_rx_sop, mac_rx_be_n, mac_rx_data}),
      .pop   (rx_pop[gp]),
      .rdata (rx_head[gp]),
      .full  (rx_full[gp]),
      .empty (rx_empty[gp])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_be_err <= 1'b0;
      ovf_flag  <= '0;
      unf_flag  <= '0;
    end else begin
      tx_be_err <= tx_be_err | (wr_req && !be_ok);
      ovf_flag  <= ovf_flag | ovf_set;
      unf_flag  <= unf_flag | unf_set;
    end
  end

  assign rx_sel_word = rx_head[port_sel];
  assign tx_sel_word = tx_head[mac_tx_port];

  rx_lane_present #(.DW(DW)) u_rxp (
    .mode      (mode),
    .active    (rd_req),
    .has_word  (!rx_empty[port_sel]),
    .head_data (rx_sel_word[DW-1:0]),
    .head_be_n (rx_sel_word[DW+NB-1:DW]),
    .head_sop  (rx_sel_word[DW+NB]),
    .head_eop  (rx_sel_word[DW+NB+1]),
    .head_fail (rx_sel_word[DW+NB+2]),
    .rd_data   (rd_data),
    .rd_be_n   (rd_be_n),
    .rd_sop    (rd_sop),
    .rd_eop    (rd_eop),
    .rd_fail   (rd_fail),
    .rd_drive  (rd_drive)
  );

  assign mac_tx_data  = tx_sel_word[DW-1:0];
  assign mac_tx_be_n  = tx_sel_word[TXW-1:DW];
  assign mac_tx_avail = ~tx_empty;
  assign mac_rx_full  = rx_full;
endmodule

// File: rtl/pkt_host_if_chk.sv
module pkt_host_if_chk #(
  parameter int NPORT = 8,
  parameter int DW    = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [1:0]               bus_mode,
  input logic [$clog2(NPORT)-1:0] port_sel,
  input logic                     tx_sel_n,
  input logic                     rx_sel_n,
  input logic                     rx_keep,
  input logic [DW/8-1:0]          rd_be_n,
  input logic                     rd_sop,
  input logic                     rd_eop,
  input logic                     rd_fail,
  input logic                     rd_drive,
  input logic                     tx_be_err,
  input logic [NPORT-1:0]         ovf_flag,
  input logic [NPORT-1:0]         unf_flag,
  input logic [NPORT-1:0]         rx_empty
);
  localparam int NB = DW / 8;

  logic [$clog2(NPORT)-1:0] last_port;
  always_ff @(posedge clk) last_port <= port_sel;

  // R5
  released_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_sel_n |-> (!rd_drive && (&rd_be_n) && !rd_sop && !rd_eop && !rd_fail));

  // R8
  keep_retains_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_sel_n && rx_keep && !rx_empty[port_sel]) |=> !rx_empty[last_port]);

  // R4
  be_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_be_err |=> tx_be_err);

  // R4
  be_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_be_err) |-> $past(!tx_sel_n));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag != '0) |=> ((ovf_flag & $past(ovf_flag)) == $past(ovf_flag)));

  // R10
  unf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_flag != $past(unf_flag)) |-> $past(!rx_sel_n));

  // R6
  halved_upper_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_drive && (bus_mode == 2'd1 || bus_mode == 2'd2)) |-> (&rd_be_n[NB-1:NB/2]));
endmodule

bind pkt_host_if pkt_host_if_chk #(.NPORT(NPORT), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_mode  (bus_mode),
  .port_sel  (port_sel),
  .tx_sel_n  (tx_sel_n),
  .rx_sel_n  (rx_sel_n),
  .rx_keep   (rx_keep),
  .rd_be_n   (rd_be_n),
  .rd_sop    (rd_sop),
  .rd_eop    (rd_eop),
  .rd_fail   (rd_fail),
  .rd_drive  (rd_drive),
  .tx_be_err (tx_be_err),
  .ovf_flag  (ovf_flag),
  .unf_flag  (unf_flag),
  .rx_empty  (rx_empty)
);

// File: tb/sim_pkt_host_if.sv
module sim_pkt_host_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  bus_mode = 2'd0;
  logic [2:0]  port_sel = '0, tx_port = '0;
  logic        tx_sel_n = 1'b1, rx_sel_n = 1'b1, rx_keep = 1'b0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_be_n = '1;
  logic [63:0] rd_data;
  logic [7:0]  rd_be_n;
  logic        rd_sop, rd_eop, rd_fail, rd_drive, tx_be_err;
  logic [7:0]  ovf_flag, unf_flag;
  logic        mac_rx_push = 1'b0;
  logic [2:0]  mac_rx_port = '0;
  logic [63:0] mac_rx_data = '0;
  logic [7:0]  mac_rx_be_n = '1;
  logic        mac_rx_sop = 1'b0, mac_rx_eop = 1'b0, mac_rx_fail = 1'b0;
  logic [7:0]  mac_rx_full;
  logic        mac_tx_pop = 1'b0;
  logic [2:0]  mac_tx_port = '0;
  logic [7:0]  mac_tx_avail;
  logic [63:0] mac_tx_data;
  logic [7:0]  mac_tx_be_n;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pkt_host_if u0 (
    .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .port_sel(port_sel), .tx_port(tx_port),
    .tx_sel_n(tx_sel_n), .rx_sel_n(rx_sel_n), .rx_keep(rx_keep),
    .wr_data(wr_data), .wr_be_n(wr_be_n), .rd_data(rd_data), .rd_be_n(rd_be_n),
    .rd_sop(rd_sop), .rd_eop(rd_eop), .rd_fail(rd_fail), .rd_drive(rd_drive),
    .tx_be_err(tx_be_err), .ovf_flag(ovf_flag), .unf_flag(unf_flag),
    .mac_rx_push(mac_rx_push), .mac_rx_port(mac_rx_port), .mac_rx_data(mac_rx_data),
    .mac_rx_be_n(mac_rx_be_n), .mac_rx_sop(mac_rx_sop), .mac_rx_eop(mac_rx_eop),
    .mac_rx_fail(mac_rx_fail), .mac_rx_full(mac_rx_full),
    .mac_tx_pop(mac_tx_pop), .mac_tx_port(mac_tx_port), .mac_tx_avail(mac_tx_avail),
    .mac_tx_data(mac_tx_data), .mac_tx_be_n(mac_tx_be_n)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] p, input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    port_sel = p; tx_port = p; wr_data = d; wr_be_n = be; tx_sel_n = 1'b0;
    @(negedge clk);
    tx_sel_n = 1'b1;
  endtask

  task automatic line_push(input logic [2:0] p, input logic [63:0] d, input logic [7:0] be,
                           input logic s, input logic e, input logic f);
    @(negedge clk);
    mac_rx_port = p; mac_rx_data = d; mac_rx_be_n = be;
    mac_rx_sop = s; mac_rx_eop = e; mac_rx_fail = f; mac_rx_push = 1'b1;
    @(negedge clk);
    mac_rx_push = 1'b0;
  endtask

  task automatic line_pop(input string req, input logic [2:0] p,
                          input logic [63:0] d, input logic [7:0] be);
    @(negedge clk);
    mac_tx_port = p;
    #1;
    chk({req, " tx data"}, mac_tx_data, d);
    chk({req, " tx be"}, {56'd0, mac_tx_be_n}, {56'd0, be});
    mac_tx_pop = 1'b1;
    @(negedge clk);
    mac_tx_pop = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 tx avail", {56'd0, mac_tx_avail}, 64'd0);
    chk("R1 rx full", {56'd0, mac_rx_full}, 64'd0);
    chk("R1 flags", {47'd0, tx_be_err, ovf_flag, unf_flag}, 64'd0);
    chk("R5 idle drive", {63'd0, rd_drive}, 64'd0);
    chk("R5 idle data", rd_data, {64{1'b1}});
    chk("R5 idle be", {56'd0, rd_be_n}, 64'hFF);
  endtask

  task automatic t_wide_write();
    bus_mode = 2'd0;
    host_write(3'd3, 64'h1122_3344_5566_7788, 8'h00);
    host_write(3'd3, 64'h0BAD_F00D_8765_4321, 8'hF0);
    bus_mode = 2'd3;
    host_write(3'd6, 64'hC0C0_C0C0_1234_0000, 8'h00);
    bus_mode = 2'd0;
    #1;
    chk("R2 avail map", {56'd0, mac_tx_avail}, 64'h48);
    line_pop("R2 first", 3'd3, 64'h1122_3344_5566_7788, 8'h00);
    line_pop("R2 second", 3'd3, 64'h0BAD_F00D_8765_4321, 8'hF0);
    line_pop("R12 mode3 wide", 3'd6, 64'hC0C0_C0C0_1234_0000, 8'h00);
    #1;
    chk("R2 drained", {56'd0, mac_tx_avail}, 64'd0);
    chk("R4 no err yet", {63'd0, tx_be_err}, 64'd0);
  endtask

  task automatic t_be_check();
    bus_mode = 2'd0;
    host_write(3'd1, 64'h1, 8'hAF);
    #1;
    chk("R4 gap dropped", {56'd0, mac_tx_avail}, 64'd0);
    chk("R4 err set", {63'd0, tx_be_err}, 64'd1);
    host_write(3'd1, 64'h2, 8'hFF);
    #1;
    chk("R4 none dropped", {56'd0, mac_tx_avail}, 64'd0);
    host_write(3'd1, 64'h3, 8'h81);
    #1;
    chk("R4 err sticky", {63'd0, tx_be_err}, 64'd1);
    line_pop("R4 run accepted", 3'd1, 64'h3, 8'h81);
  endtask

  task automatic t_rx_wide();
    bus_mode = 2'd0;
    line_push(3'd2, 64'hAAAA_0000_BBBB_1111, 8'h00, 1'b1, 1'b0, 1'b0);
    line_push(3'd2, 64'h0000_0000_00CC_DDEE, 8'hF8, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    port_sel = 3'd2; rx_keep = 1'b0; rx_sel_n = 1'b0;
    #1;
    chk("R3 drive", {63'd0, rd_drive}, 64'd1);
    chk("R3 data0", rd_data, 64'hAAAA_0000_BBBB_1111);
    chk("R3 marks0", {56'd0, rd_be_n, rd_sop, rd_eop, rd_fail} >> 3, {56'd0, 8'h00, 3'b100} >> 3);
    chk("R3 sop0", {61'd0, rd_sop, rd_eop, rd_fail}, 64'b100);
    @(negedge clk);
    #1;
    chk("R3 data1", rd_data, 64'h0000_0000_00CC_DDEE);
    chk("R3 be1", {56'd0, rd_be_n}, 64'hF8);
    chk("R3 marks1", {61'd0, rd_sop, rd_eop, rd_fail}, 64'b011);
    @(negedge clk);
    rx_sel_n = 1'b1;
    #1;
    chk("R5 released", {rd_data[62:0], rd_drive}, {63'h7FFF_FFFF_FFFF_FFFF, 1'b0});
  endtask

  task automatic t_keep();
    bus_mode = 2'd0;
    line_push(3'd4, 64'hF1F1, 8'h00, 1'b1, 1'b0, 1'b0);
    line_push(3'd4, 64'hF2F2, 8'h00, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    rx_keep = 1'b1;
    @(negedge clk);
    rx_keep = 1'b0;
    #1;
    chk("R8 keep idle no effect", {63'd0, rd_drive}, 64'd0);
    port_sel = 3'd4; rx_keep = 1'b1; rx_sel_n = 1'b0;
    #1;
    chk("R8 first look", rd_data, 64'hF1F1);
    @(negedge clk);
    #1;
    chk("R8 kept", rd_data, 64'hF1F1);
    rx_keep = 1'b0;
    @(negedge clk);
    #1;
    chk("R8 popped after", rd_data, 64'hF2F2);
    @(negedge clk);
    rx_sel_n = 1'b1;
  endtask

  task automatic t_narrow();
    bus_mode = 2'd1;
    host_write(3'd0, 64'hDEAD_BEEF_0123_4567, 8'h00);
    line_pop("R6 narrow tx", 3'd0, 64'h0000_0000_0123_4567, 8'hF0);
    host_write(3'd0, 64'h5, 8'h0F);
    #1;
    chk("R6 upper be ignored", {56'd0, mac_tx_avail}, 64'd0);
    line_push(3'd0, 64'hAAAA_BBBB_CCCC_DDDD, 8'h00, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    port_sel = 3'd0; rx_sel_n = 1'b0;
    #1;
    chk("R6 narrow rx data", rd_data, 64'hFFFF_FFFF_CCCC_DDDD);
    chk("R6 narrow rx be", {56'd0, rd_be_n}, 64'hF0);
    @(negedge clk);
    rx_sel_n = 1'b1;
  endtask

  task automatic t_split();
    bus_mode = 2'd2;
    line_push(3'd2, 64'h1234_5678_9ABC_DEF0, 8'h00, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    port_sel = 3'd2; tx_port = 3'd5;
    wr_data = 64'hCAFE_F00D_0000_0000; wr_be_n = 8'h0F;
    tx_sel_n = 1'b0; rx_sel_n = 1'b0;
    #1;
    chk("R7 split rx data", rd_data, 64'hFFFF_FFFF_9ABC_DEF0);
    chk("R7 split rx be", {56'd0, rd_be_n}, 64'hF0);
    @(negedge clk);
    tx_sel_n = 1'b1; rx_sel_n = 1'b1;
    #1;
    chk("R7 split tx landed", {56'd0, mac_tx_avail}, 64'h20);
    line_pop("R7 split tx", 3'd5, 64'h0000_0000_CAFE_F00D, 8'hF0);
  endtask

  task automatic t_conflict();
    bus_mode = 2'd0;
    line_push(3'd7, 64'h7777, 8'h00, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    port_sel = 3'd7; wr_data = 64'h9999; wr_be_n = 8'h00;
    tx_sel_n = 1'b0; rx_sel_n = 1'b0;
    #1;
    chk("R11 read served", rd_data, 64'h7777);
    @(negedge clk);
    tx_sel_n = 1'b1; rx_sel_n = 1'b1;
    #1;
    chk("R11 write ignored", {56'd0, mac_tx_avail}, 64'd0);
  endtask

  task automatic t_over_under();
    bus_mode = 2'd0;
    for (int i = 0; i < 16; i++) host_write(3'd2, 64'(i), 8'h00);
    #1;
    chk("R9 no ovf at full", {56'd0, ovf_flag}, 64'd0);
    host_write(3'd2, 64'hEE, 8'h00);
    #1;
    chk("R9 ovf set", {56'd0, ovf_flag}, 64'h04);
    line_pop("R9 oldest", 3'd2, 64'd0, 8'h00);
    for (int i = 1; i < 15; i++) begin
      @(negedge clk); mac_tx_port = 3'd2; mac_tx_pop = 1'b1;
      @(negedge clk); mac_tx_pop = 1'b0;
    end
    line_pop("R9 last kept", 3'd2, 64'd15, 8'h00);
    #1;
    chk("R9 extra not stored", {56'd0, mac_tx_avail}, 64'd0);
    chk("R9 ovf sticky", {56'd0, ovf_flag}, 64'h04);
    @(negedge clk);
    port_sel = 3'd1; rx_sel_n = 1'b0;
    #1;
    chk("R10 empty data", rd_data, 64'd0);
    chk("R10 empty be", {53'd0, rd_be_n, rd_sop, rd_eop, rd_fail, rd_drive} , {53'd0, 8'hFF, 4'b0001});
    @(negedge clk);
    rx_sel_n = 1'b1;
    #1;
    chk("R10 unf set", {56'd0, unf_flag}, 64'h02);
  endtask

  task automatic t_flush();
    bus_mode = 2'd0;
    host_write(3'd4, 64'h44, 8'h00);
    line_push(3'd4, 64'h45, 8'h00, 1'b0, 1'b0, 1'b0);
    do_reset();
    #1;
    chk("R1 tx flushed", {56'd0, mac_tx_avail}, 64'd0);
    chk("R1 flags cleared", {47'd0, tx_be_err, ovf_flag, unf_flag}, 64'd0);
    @(negedge clk);
    port_sel = 3'd4; rx_sel_n = 1'b0;
    #1;
    chk("R1 rx flushed", rd_data, 64'd0);
    @(negedge clk);
    rx_sel_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_wide_write();
    t_be_check();
    t_rx_wide();
    t_keep();
    t_narrow();
    t_split();
    t_conflict();
    t_over_under();
    t_flush();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule